// File: doc/BRIEF.md
# Burst Address Sequencer with Cache-Line Wrap

This block sits in the memory-target side of a parallel bus interface and produces the DWORD address for every data phase of a burst. When a transaction starts, it captures the starting byte address. The two lowest bits of that address are not part of the DWORD address. They carry a burst-order code, and the block keeps that code for the whole burst. Each time a data phase completes, the block steps the address by the order that the code selects.

Two orders are supported:
- **Linear order** moves up one DWORD per phase.
- **Wrap order** walks the rest of the cache line, rolls over to the start of that line, and finishes the whole line. It then carries on in the next line at the offset where the burst began.

The block raises a disconnect request for the other cases: the reserved codes, and wrap order on a build without wrap support. The request lets the bus logic stop the burst after one phase. The cache line length, the address width and wrap support are all fixed when the design is elaborated.

The data-phase handshake works like a valid/ready pair. A phase completes only in a cycle where the initiator-ready strobe and the target-ready strobe are both high. Either side can hold the other back by keeping its strobe low, and the address then waits. Start and end are plain single-cycle pulses.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `busy_o` is 0, `addr_o` is 0 and `disconnect_o` is 0.
- R2: A `start_i` pulse loads `addr_o` with `start_addr_i` and its two low bits forced to 0 in the next cycle, and sets `busy_o`. The burst-order code is `start_addr_i[1:0]`.
- R3: A data phase completes only when `busy_o`, `mst_rdy_i` and `tgt_rdy_i` are all high at a clock edge. In any other cycle without a start, `addr_o` holds its value.
- R4: Code 00 (linear): each completed phase adds 4 to `addr_o`.
- R5: Code 10 (wrap): from an offset inside a line of LINE_DW DWORDs, the addresses climb to the end of the line and then roll over to the line start. This continues until LINE_DW phases have covered the line.
- R6: Code 10: after a full line, the next address is in the following line at the starting offset. For example, with 4-DWORD lines and a start at 0x8, the order is 0x8, 0xC, 0x0, 0x4, 0x18.
- R7: Code 10 with a line-aligned start gives the same sequence as linear order.
- R8: Codes 01 and 11: `disconnect_o` stays 0 until the first phase completes. From the next cycle it stays 1 until the transaction ends, and `addr_o` no longer changes.
- R9: With WRAP_EN = 0, code 10 behaves exactly like codes 01 and 11.
- R10: An `end_i` pulse clears `busy_o` and `disconnect_o` in the next cycle. A `start_i` in the same cycle as `end_i`, or during a burst, takes priority and starts a new burst.
- R11: Codes 00 and 10 (the latter with WRAP_EN = 1) never assert `disconnect_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that starts a burst |
| start_addr_i | input | ADDR_W | Start byte address; bits [1:0] carry the order code |
| end_i | input | 1 | Pulse that ends the transaction |
| mst_rdy_i | input | 1 | Initiator ready strobe |
| tgt_rdy_i | input | 1 | Target ready strobe |
| busy_o | output | 1 | A burst is in progress |
| addr_o | output | ADDR_W | Byte address of the current data phase |
| disconnect_o | output | 1 | Request to stop the burst |

## Verification
The hardest case to reach is the move from the last DWORD of a wrapped line into the next line at the original offset. The burst has to start at every offset and survive more than one full line of completed phases, with stalls arriving in uneven places along the way. The bench sweeps every order code over every start offset across two lines, using two different stall patterns. It drives a wrap-capable instance and a wrap-less instance in parallel. Both are compared on every cycle against addresses computed by line arithmetic.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic [1:0] {
    ORD_LINEAR = 2'd0,
    ORD_WRAP   = 2'd1,
    ORD_SINGLE = 2'd2
  } burst_ord_e;
endpackage

// File: rtl/burst_order_decode.sv
module burst_order_decode
  import burst_seq_pkg::*;
#(
  parameter bit WRAP_EN = 1'b1
) (
  input  logic [1:0]  code_i,
  output burst_ord_e  ord_o
);
  if (WRAP_EN) begin : g_wrap
    always_comb begin
      unique case (code_i)
        2'b00:   ord_o = ORD_LINEAR;
        2'b10:   ord_o = ORD_WRAP;
        default: ord_o = ORD_SINGLE;
      endcase
    end
  end else begin : g_nowrap
    always_comb ord_o = (code_i == 2'b00) ? ORD_LINEAR : ORD_SINGLE;
  end
endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int DW_W  = 30,
  parameter int OFF_W = 3
) (
  input  burst_ord_e        ord_i,
  input  logic [DW_W-1:0]   cur_i,
  input  logic [OFF_W-1:0]  start_off_i,
  input  logic [OFF_W-1:0]  beat_i,
  output logic [DW_W-1:0]   nxt_o,
  output logic [OFF_W-1:0]  beat_nxt_o
);
  localparam int              LINE_W = DW_W - OFF_W;
  localparam logic [OFF_W-1:0] LAST  = '1;

  always_comb begin
    nxt_o      = cur_i;
    beat_nxt_o = beat_i;
    unique case (ord_i)
      ORD_LINEAR: nxt_o = cur_i + DW_W'(1);
      ORD_WRAP: begin
        beat_nxt_o = beat_i + OFF_W'(1);
        if (beat_i == LAST)
          nxt_o = {cur_i[DW_W-1:OFF_W] + LINE_W'(1), start_off_i};
        else
          nxt_o = {cur_i[DW_W-1:OFF_W], cur_i[OFF_W-1:0] + OFF_W'(1)};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int LINE_DW = 8,
  parameter bit WRAP_EN = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              end_i,
  input  logic              mst_rdy_i,
  input  logic              tgt_rdy_i,
  output logic              busy_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              disconnect_o
);
  localparam int DW_W  = ADDR_W - 2;
  localparam int OFF_W = $clog2(LINE_DW);

  burst_ord_e             ord_dec, ord_q;
  logic [DW_W-1:0]        cur_q, nxt;
  logic [OFF_W-1:0]       off_q, beat_q, beat_nxt;
  logic                   busy_q, disc_q, adv;

  burst_order_decode #(.WRAP_EN(WRAP_EN)) u_dec (
    .code_i (start_addr_i[1:0]),
    .ord_o  (ord_dec)
  );

  burst_addr_step #(.DW_W(DW_W), .OFF_W(OFF_W)) u_step (
    .ord_i       (ord_q),
    .cur_i       (cur_q),
    .start_off_i (off_q),
    .beat_i      (beat_q),
    .nxt_o       (nxt),
    .beat_nxt_o  (beat_nxt)
  );

  assign adv = busy_q & mst_rdy_i & tgt_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cur_q  <= '0;
      off_q  <= '0;
      beat_q <= '0;
      ord_q  <= ORD_LINEAR;
      disc_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cur_q  <= start_addr_i[ADDR_W-1:2];
      off_q  <= start_addr_i[OFF_W+1:2];
      beat_q <= '0;
      ord_q  <= ord_dec;
      disc_q <= 1'b0;
    end else begin
      if (adv) begin
        cur_q  <= nxt;
        beat_q <= beat_nxt;
        if (ord_q == ORD_SINGLE) disc_q <= 1'b1;
      end
      if (end_i) begin
        busy_q <= 1'b0;
        disc_q <= 1'b0;
      end
    end
  end

  assign busy_o       = busy_q;
  assign addr_o       = {cur_q, 2'b00};
  assign disconnect_o = disc_q;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              end_i,
  input logic              mst_rdy_i,
  input logic              tgt_rdy_i,
  input logic              busy_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              disconnect_o
);
  logic [1:0] code_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= 2'b00;
    else if (start_i) code_q <= start_addr_i[1:0];
  end

  p_start_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> busy_o && addr_o == {$past(start_addr_i[ADDR_W-1:2]), 2'b00});

  p_stall_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !(busy_o && mst_rdy_i && tgt_rdy_i)) |=> $stable(addr_o));

  p_linear_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && code_q == 2'b00 && mst_rdy_i && tgt_rdy_i && !start_i)
      |=> addr_o == $past(addr_o) + ADDR_W'(4));

  p_disc_freeze_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disconnect_o && !start_i) |=> $stable(addr_o));

  p_disc_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (disconnect_o && !start_i && !end_i) |=> disconnect_o);

  p_disc_needs_busy_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disconnect_o |-> busy_o);

  p_end_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_i && !start_i) |=> !busy_o && !disconnect_o);

  p_linear_no_disc_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && code_q == 2'b00) |-> !disconnect_o);
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .end_i        (end_i),
  .mst_rdy_i    (mst_rdy_i),
  .tgt_rdy_i    (tgt_rdy_i),
  .busy_o       (busy_o),
  .addr_o       (addr_o),
  .disconnect_o (disconnect_o)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW   = 12;
  localparam int LDW  = 4;
  localparam int LB   = LDW * 4;
  localparam int BEATS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, fin = 1'b0, mrdy = 1'b0, trdy = 1'b0;
  logic [AW-1:0] saddr = '0;
  logic busy_w, disc_w, busy_n, disc_n;
  logic [AW-1:0] addr_w, addr_n;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .LINE_DW(LDW), .WRAP_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .end_i(fin), .mst_rdy_i(mrdy), .tgt_rdy_i(trdy),
    .busy_o(busy_w), .addr_o(addr_w), .disconnect_o(disc_w));

  burst_addr_seq #(.ADDR_W(AW), .LINE_DW(LDW), .WRAP_EN(1'b0)) dut_nowrap (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(saddr),
    .end_i(fin), .mst_rdy_i(mrdy), .tgt_rdy_i(trdy),
    .busy_o(busy_n), .addr_o(addr_n), .disconnect_o(disc_n));

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
      report();
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_addr(input int code, input bit wrap_ok, input int s, input int n);
    int line0, off;
    if (code == 0) return (s + 4*n) % (1 << AW);
    if (code == 2 && wrap_ok) begin
      line0 = s - (s % LB);
      off   = s % LB;
      return line0 + (n / LDW) * LB + ((off + 4*(n % LDW)) % LB);
    end
    return s;
  endfunction

  function automatic string addr_tag(input int code, input bit wrap_ok, input int s, input int n);
    if (code == 0) return "R4";
    if (code == 2 && !wrap_ok) return "R9";
    if (code == 2 && s % LB == 0) return "R7";
    if (code == 2) return (n < LDW) ? "R5" : "R6";
    return "R8";
  endfunction

  task automatic run_burst(input int code, input int s_dw, input int patt);
    int s, n, g;
    bit ew, en;
    s = 'h200 + s_dw*4;
    n = 0;
    g = 0;
    start = 1'b1;
    saddr = AW'(s + code);
    @(negedge clk);
    start = 1'b0;
    check(busy_w && addr_w == AW'(s), "R2", int'(addr_w), s);
    while (n < BEATS) begin
      check(int'(addr_w) == exp_addr(code, 1'b1, s, n), addr_tag(code, 1'b1, s, n),
            int'(addr_w), exp_addr(code, 1'b1, s, n));
      check(int'(addr_n) == exp_addr(code, 1'b0, s, n), addr_tag(code, 1'b0, s, n),
            int'(addr_n), exp_addr(code, 1'b0, s, n));
      ew = (code == 1 || code == 3) && n >= 1;
      en = (code != 0) && n >= 1;
      check(disc_w == ew, (code == 0 || code == 2) ? "R11" : "R8", int'(disc_w), int'(ew));
      check(disc_n == en, (code == 2) ? "R9" : ((code == 0) ? "R11" : "R8"), int'(disc_n), int'(en));
      mrdy = ((n + g + patt) % 3) != 0;
      trdy = ((g + patt) % 4) != 1;
      @(negedge clk);
      if (mrdy && trdy) n++;
      g++;
    end
    mrdy = 1'b0;
    trdy = 1'b0;
    fin = 1'b1;
    @(negedge clk);
    fin = 1'b0;
    check(!busy_w && !disc_w && !disc_n, "R10", int'({busy_w, disc_w, disc_n}), 0);
  endtask

  initial begin
    @(negedge clk);
    check(!busy_w && addr_w == '0 && !disc_w, "R1", int'({busy_w, disc_w}), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R3: one strobe alone never advances
    start = 1'b1; saddr = AW'('h40); @(negedge clk); start = 1'b0;
    mrdy = 1'b1; trdy = 1'b0;
    repeat (3) @(negedge clk);
    check(addr_w == AW'('h40), "R3", int'(addr_w), 'h40);
    mrdy = 1'b0; trdy = 1'b1;
    repeat (3) @(negedge clk);
    check(addr_w == AW'('h40), "R3", int'(addr_w), 'h40);
    mrdy = 1'b1; @(negedge clk); mrdy = 1'b0; trdy = 1'b0;
    check(addr_w == AW'('h44), "R3", int'(addr_w), 'h44);

    // R10: restart during a burst, and start with end in the same cycle
    start = 1'b1; saddr = AW'('h80 + 2); @(negedge clk); start = 1'b0;
    check(busy_w && addr_w == AW'('h80), "R10", int'(addr_w), 'h80);
    start = 1'b1; fin = 1'b1; saddr = AW'('h10); @(negedge clk);
    start = 1'b0; fin = 1'b0;
    check(busy_w && addr_w == AW'('h10), "R10", int'({busy_w, addr_w}), int'({1'b1, 12'h10}));
    fin = 1'b1; @(negedge clk); fin = 1'b0;

    for (int patt = 0; patt < 2; patt++)
      for (int code = 0; code < 4; code++)
        for (int sd = 0; sd < 2*LDW; sd++)
          run_burst(code, sd, patt);

    report();
    $finish;
  end
endmodule